// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block holds a processor in reset while any of three conditions is present, and keeps it there for a fixed settling period once they are all gone. The conditions are a low supply-good flag from an external comparator, a low level on a manual reset request, and a watchdog that has gone without service. Every source, once cleared, leads into the same stretch period of `STRETCH_CYC` clock cycles. Two reset outputs are driven: an active-low one and an active-high one, which are always exact complements.

The supply-good flag and the manual request pass through two-flop synchronizers and then through low-level filters. Short low pulses on either line are ignored. The watchdog arms only once reset has been released. It restarts on any rising or falling edge of the strobe input, and it bites after `WD_TIMEOUT_CYC` cycles without one. The block also drives a pull-direction output. This output is low for the first seven eighths of every watchdog period and high for the last eighth. A strobe line that only follows this pattern counts as undriven, and the watchdog then stays serviced internally. A line that shows a level opposite to the pull in either phase counts as driven.

The controller is a three-state machine. In ST_HOLD at least one source is active. ST_STRETCH counts the settling period. ST_RUN is the released state. Its transitions are named as follows. `hold_done` goes from ST_HOLD to ST_STRETCH when all sources are clear. `stretch_end` goes from ST_STRETCH to ST_RUN when the count completes. `src_hit` goes to ST_HOLD from ST_STRETCH or ST_RUN when a source becomes active. `wd_bite` goes from ST_RUN to ST_STRETCH when the watchdog expires.

Top module: `rst_supervisor`

## Requirements
- R1: A supply-good low lasting at least `SUP_FILT_CYC` clock cycles asserts reset no later than `SUP_FILT_CYC`+3 cycles after it starts. A shorter low has no effect.
- R2: Reset is released exactly `STRETCH_CYC`+3 cycles after the supply-good flag returns high, provided no other source is active. No release happens before a full stretch count.
- R3: `sys_rst_n` is always the inverse of `sys_rst`.
- R4: A manual request held low for at least `MR_FILT_CYC` cycles asserts reset, and reset stays asserted for as long as the request is low. A shorter low pulse has no effect.
- R5: The stretch starts when the manual request returns high. Reset is released exactly `STRETCH_CYC`+3 cycles after that rise.
- R6: While the strobe line is driven at a constant level, reset is released for exactly `WD_TIMEOUT_CYC` cycles. It is then asserted for exactly `STRETCH_CYC` cycles, and the sequence repeats. The watchdog counter is idle while reset is asserted.
- R7: A rising or a falling strobe edge at intervals below `WD_TIMEOUT_CYC` cycles keeps reset released.
- R8: `wd_pull_hi` is 0 while `por_n` is low. It is then high for `WD_TIMEOUT_CYC`/8 consecutive cycles and low for the remaining 7/8 of each `WD_TIMEOUT_CYC`-cycle period.
- R9: A strobe line that only follows `wd_pull_hi` causes no watchdog reset.
- R10: A strobe held low against the high pull phase counts as driven, so the watchdog still expires.
- R11: While `por_n` is low, `sys_rst_n` is 0 and `sys_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low initialisation of the block's own flops |
| supply_ok | input | 1 | Supply-good flag from an external comparator (high = good) |
| man_rst_n | input | 1 | Manual reset request, active low |
| wd_strobe | input | 1 | Watchdog strobe line |
| sys_rst_n | output | 1 | Processor reset, active low |
| sys_rst | output | 1 | Processor reset, active high |
| wd_pull_hi | output | 1 | Pull direction for the strobe line (1 = pull up) |

## Verification
The bench measures release latency after supply and manual recovery to the exact cycle. A design that starts the stretch when the manual request first falls, or that loses a synchronizer stage, is off by cycles there. It times the watchdog bite, the stretch and the next bite back to back. An off-by-one in either counter, or a watchdog that counts during reset, changes those lengths. Glitches one cycle shorter than each filter must leave reset released, which catches a filter that is one cycle too eager. A strobe that follows the pull pattern must never cause a bite, while a strobe stuck low must cause one. A float detector that is too loose masks a hung processor, and one that is too strict bites on an open line.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_t;
endpackage

// File: rtl/sup_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
module sup_sync #(
    parameter int               W    = 1,
    parameter logic [W-1:0]     INIT = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                meta <= INIT[i];
                q[i] <= INIT[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/sup_lowfilt.sv
// Flags a synchronized active-low level once it has been low for LEN
// consecutive cycles; the flag drops on the first high sample.
module sup_lowfilt #(
    parameter int   LEN         = 4,
    parameter logic INIT_ACTIVE = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic lvl,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(LEN);
    localparam logic [CW-1:0] CNT_TRIP = CW'(LEN - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt <= '0;
            active  <= INIT_ACTIVE;
        end else if (lvl) begin
            low_cnt <= '0;
            active  <= 1'b0;
        end else begin
            if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
            if (low_cnt == CNT_TRIP) active <= 1'b1;
        end
    end
endmodule

// File: rtl/sup_wdog.sv
// Edge-restarted watchdog with pull-pattern float detection.
module sup_wdog #(
    parameter int TMO = 256
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   arm,
    input  logic                   strobe_s,
    output logic                   pull_hi,
    output logic                   expire,
    output logic [$clog2(TMO)-1:0] cnt_o,
    output logic [$clog2(TMO)-1:0] phase_o
);
    localparam int CW = $clog2(TMO);
    localparam logic [CW-1:0] LAST    = CW'(TMO - 1);
    localparam logic [CW-1:0] PULL_PRE = CW'(TMO - TMO / 8 - 1);

    logic [CW-1:0] phase;
    logic [CW-1:0] cnt;
    logic          pull_d1, pull_d2;
    logic          strobe_prev;
    logic          drv_cur, drv_prev;
    logic          mismatch, kick, drv_seen, hold0;

    // free-running pull-pattern period
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            phase   <= '0;
            pull_hi <= 1'b0;
        end else begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
            if (phase == PULL_PRE)  pull_hi <= 1'b1;
            else if (phase == LAST) pull_hi <= 1'b0;
        end
    end

    // pull delayed to line up with the synchronizer depth
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pull_d1     <= 1'b0;
            pull_d2     <= 1'b0;
            strobe_prev <= 1'b0;
        end else begin
            pull_d1     <= pull_hi;
            pull_d2     <= pull_d1;
            strobe_prev <= strobe_s;
        end
    end

    always_comb begin
        mismatch = (strobe_s != pull_d2);
        kick     = (strobe_s != strobe_prev);
        drv_seen = drv_cur | drv_prev;
        hold0    = !arm || kick || !drv_seen;
        expire   = !hold0 && (cnt == LAST);
    end

    // driven history: current and previous period
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            drv_cur  <= 1'b0;
            drv_prev <= 1'b0;
        end else if (phase == LAST) begin
            drv_prev <= drv_cur | mismatch;
            drv_cur  <= 1'b0;
        end else begin
            drv_cur  <= drv_cur | mismatch;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)               cnt <= '0;
        else if (hold0 || expire) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign cnt_o   = cnt;
    assign phase_o = phase;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int STRETCH_CYC    = 64,
    parameter int WD_TIMEOUT_CYC = 256,
    parameter int MR_FILT_CYC    = 8,
    parameter int SUP_FILT_CYC   = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic man_rst_n,
    input  logic wd_strobe,
    output logic sys_rst_n,
    output logic sys_rst,
    output logic wd_pull_hi
);
    import sup_pkg::*;

    localparam int SCW = $clog2(STRETCH_CYC);
    localparam int WCW = $clog2(WD_TIMEOUT_CYC);
    localparam logic [SCW-1:0] STRETCH_LAST = SCW'(STRETCH_CYC - 1);

    logic [2:0]     in_s;
    logic           sup_fault, mr_active, any_src;
    logic           wd_expire;
    logic [WCW-1:0] wd_cnt, wd_phase;
    logic [SCW-1:0] stretch_cnt;
    sup_state_t     state_q, state_d;

    sup_sync #(.W(3), .INIT(3'b010)) u_sync (
        .clk(clk), .por_n(por_n),
        .d({wd_strobe, man_rst_n, supply_ok}),
        .q(in_s)
    );

    sup_lowfilt #(.LEN(SUP_FILT_CYC), .INIT_ACTIVE(1'b1)) u_sup_filt (
        .clk(clk), .por_n(por_n), .lvl(in_s[0]), .active(sup_fault)
    );

    sup_lowfilt #(.LEN(MR_FILT_CYC), .INIT_ACTIVE(1'b0)) u_mr_filt (
        .clk(clk), .por_n(por_n), .lvl(in_s[1]), .active(mr_active)
    );

    sup_wdog #(.TMO(WD_TIMEOUT_CYC)) u_wdog (
        .clk(clk), .por_n(por_n),
        .arm(state_q == ST_RUN),
        .strobe_s(in_s[2]),
        .pull_hi(wd_pull_hi),
        .expire(wd_expire),
        .cnt_o(wd_cnt),
        .phase_o(wd_phase)
    );

    assign any_src = sup_fault | mr_active;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!any_src) state_d = ST_STRETCH;            // hold_done
            ST_STRETCH: if (any_src) state_d = ST_HOLD;                // src_hit
                        else if (stretch_cnt == STRETCH_LAST)
                            state_d = ST_RUN;                          // stretch_end
            ST_RUN:     if (any_src) state_d = ST_HOLD;                // src_hit
                        else if (wd_expire) state_d = ST_STRETCH;      // wd_bite
            default:    state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            stretch_cnt <= '0;
        else if (state_q == ST_STRETCH && state_d == ST_STRETCH)
            stretch_cnt <= stretch_cnt + 1'b1;
        else
            stretch_cnt <= '0;
    end

    // outputs
    always_comb begin
        sys_rst   = (state_q != ST_RUN);
        sys_rst_n = (state_q == ST_RUN);
    end
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int STRETCH_CYC    = 64,
    parameter int WD_TIMEOUT_CYC = 256
) (
    input logic                              clk,
    input logic                              por_n,
    input logic                              sys_rst_n,
    input logic                              sys_rst,
    input logic                              wd_pull_hi,
    input logic                              sup_fault,
    input logic                              mr_active,
    input logic                              wd_expire,
    input logic [$clog2(WD_TIMEOUT_CYC)-1:0] wd_cnt,
    input logic [$clog2(WD_TIMEOUT_CYC)-1:0] wd_phase,
    input logic [$clog2(STRETCH_CYC)-1:0]    stretch_cnt
);
    a_r3_complement: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_n != sys_rst);

    a_r1_supply_forces: assert property (@(posedge clk) disable iff (!por_n)
        sup_fault |=> sys_rst);

    a_r4_manual_forces: assert property (@(posedge clk) disable iff (!por_n)
        mr_active |=> sys_rst);

    a_r2_full_stretch: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> ($past(stretch_cnt) == ($clog2(STRETCH_CYC))'(STRETCH_CYC - 1)));

    a_r6_bite_stretches: assert property (@(posedge clk) disable iff (!por_n)
        wd_expire |=> (sys_rst && stretch_cnt == '0));

    a_r6_idle_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (wd_cnt == '0));

    a_r8_pull_drops_at_wrap: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wd_pull_hi) |-> (wd_phase == '0));
endmodule

bind rst_supervisor rst_supervisor_chk #(
    .STRETCH_CYC(STRETCH_CYC),
    .WD_TIMEOUT_CYC(WD_TIMEOUT_CYC)
) u_chk (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst),
    .wd_pull_hi(wd_pull_hi), .sup_fault(sup_fault), .mr_active(mr_active),
    .wd_expire(wd_expire), .wd_cnt(wd_cnt), .wd_phase(wd_phase),
    .stretch_cnt(stretch_cnt)
);

// File: tb/rst_supervisor_tb.sv
`timescale 1ns/1ps
module rst_supervisor_tb;
    localparam int S   = 64;
    localparam int TMO = 256;
    localparam int MRF = 8;
    localparam int SPF = 4;

    typedef struct packed {
        logic        sup;
        logic        mr;
        logic [15:0] cyc;
        logic        exp_n;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b0, 1'b1, 16'd20, 1'b0},   // R1 supply bad
        '{1'b1, 1'b1, 16'd40, 1'b0},   // R2 still stretching
        '{1'b1, 1'b1, 16'd40, 1'b1},   // R2 released
        '{1'b0, 1'b1, 16'd3,  1'b1},   // R1 glitch SPF-1
        '{1'b1, 1'b1, 16'd10, 1'b1},   // R1 glitch ignored
        '{1'b0, 1'b1, 16'd10, 1'b0},   // R1 long low
        '{1'b1, 1'b1, 16'd20, 1'b0},   // R2
        '{1'b1, 1'b1, 16'd60, 1'b1},   // R2
        '{1'b1, 1'b0, 16'd7,  1'b1},   // R4 short pulse MRF-1
        '{1'b1, 1'b1, 16'd12, 1'b1},   // R4 short pulse ignored
        '{1'b1, 1'b0, 16'd20, 1'b0},   // R4 held low
        '{1'b1, 1'b1, 16'd30, 1'b0},   // R5 stretching
        '{1'b1, 1'b1, 16'd50, 1'b1}    // R5 released
    };

    logic clk = 1'b0;
    logic por_n, supply_ok, man_rst_n;
    logic strb_lvl, kick_tog, kick_en, float_md;
    int   kick_per;
    logic sys_rst_n, sys_rst, wd_pull_hi;
    logic wd_strobe;
    int   n_chk = 0, n_fail = 0, comp_err = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    assign wd_strobe = float_md ? wd_pull_hi : (strb_lvl ^ kick_tog);

    rst_supervisor #(
        .STRETCH_CYC(S), .WD_TIMEOUT_CYC(TMO),
        .MR_FILT_CYC(MRF), .SUP_FILT_CYC(SPF)
    ) u_dut (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok),
        .man_rst_n(man_rst_n), .wd_strobe(wd_strobe),
        .sys_rst_n(sys_rst_n), .sys_rst(sys_rst), .wd_pull_hi(wd_pull_hi)
    );

    // background kick generator
    int kcnt = 0;
    initial kick_tog = 1'b0;
    always @(negedge clk) begin
        if (kick_en) begin
            if (kcnt >= kick_per - 1) begin
                kcnt     <= 0;
                kick_tog <= ~kick_tog;
            end else begin
                kcnt <= kcnt + 1;
            end
        end else begin
            kcnt <= 0;
        end
    end

    // R3 complement monitor
    always @(negedge clk) if (sys_rst_n === sys_rst) comp_err++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count consecutive samples at the given level, starting with the current one
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (sys_rst_n == lvl && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        int n;
        int falls;
        por_n = 1'b0; supply_ok = 1'b0; man_rst_n = 1'b1;
        strb_lvl = 1'b0; kick_en = 1'b0; float_md = 1'b0; kick_per = 32;
        step(5);
        // R11 reset state
        chk("R11 sys_rst_n in por", sys_rst_n, 0);
        chk("R11 sys_rst in por", sys_rst, 1);
        chk("R8 pull low in por", wd_pull_hi, 0);
        por_n = 1'b1;
        kick_en = 1'b1;

        // vector table walk
        for (int i = 0; i < 13; i++) begin
            supply_ok = VECS[i].sup;
            man_rst_n = VECS[i].mr;
            step(int'(VECS[i].cyc));
            chk($sformatf("table entry %0d (R1/R2/R4/R5)", i), sys_rst_n, VECS[i].exp_n);
        end

        // R2 exact supply release latency
        supply_ok = 1'b0;
        step(12);
        supply_ok = 1'b1;
        step(1);
        run_len(1'b0, n);
        chk("R2 supply release latency", n, S + 3);

        // R4 hold and R5 exact manual release latency
        step(20);
        man_rst_n = 1'b0;
        step(100);
        chk("R4 reset held during long manual low", sys_rst_n, 0);
        man_rst_n = 1'b1;
        step(1);
        run_len(1'b0, n);
        chk("R5 manual release latency", n, S + 3);

        // R6 constant driven strobe: bite, stretch, bite
        kick_en = 1'b0;
        strb_lvl = 1'b1 ^ kick_tog;
        n = 0;
        while (sys_rst_n == 1'b1 && n < 4 * TMO) begin n++; step(1); end
        chk("R6 first bite occurs", sys_rst_n, 0);
        run_len(1'b0, n);
        chk("R6 stretch after bite", n, S);
        run_len(1'b1, n);
        chk("R6 released window length", n, TMO);
        run_len(1'b0, n);
        chk("R6 repeated stretch", n, S);

        // R7 kicks on both edges keep reset released
        kick_per = TMO / 2;
        kick_en = 1'b1;
        n = 0;
        for (int c = 0; c < 4 * TMO; c++) begin
            if (sys_rst_n == 1'b0) n++;
            step(1);
        end
        chk("R7 periodic kicks prevent bite", n, 0);

        // R8 pull pattern shape
        while (wd_pull_hi == 1'b1) step(1);
        while (wd_pull_hi == 1'b0) step(1);
        n = 0;
        while (wd_pull_hi == 1'b1 && n < 2 * TMO) begin n++; step(1); end
        chk("R8 pull high length", n, TMO / 8);
        n = 0;
        while (wd_pull_hi == 1'b0 && n < 2 * TMO) begin n++; step(1); end
        chk("R8 pull low length", n, TMO - TMO / 8);

        // R9 floating strobe follows pull: no bite after settling
        kick_en = 1'b0;
        float_md = 1'b1;
        step(3 * TMO + 2 * S);
        n = 0;
        for (int c = 0; c < 4 * TMO; c++) begin
            if (sys_rst_n == 1'b0) n++;
            step(1);
        end
        chk("R9 floating line causes no reset", n, 0);

        // R10 strobe stuck low is driven, watchdog bites
        float_md = 1'b0;
        strb_lvl = kick_tog;
        falls = 0;
        for (int c = 0; c < 4 * TMO; c++) begin
            if (sys_rst_n == 1'b0) falls = 1;
            step(1);
        end
        chk("R10 stuck-low strobe still bites", falls, 1);

        chk("R3 complementary outputs", comp_err, 0);
        finish_up();
    end
endmodule